// File: doc/BRIEF.md
# Colour Lookup Table with Sequenced Register Port

This block holds a colour lookup table for a pixel pipeline and lets a processor load or inspect it through a narrow 32-bit register window. There are 256 ordinary entries and 4 overlay entries that serve as cursor colours. Each entry has an 8-bit red, green and blue value. Software writes the index register once. It then streams colour components through a data port. The block steps through red, green and blue on its own and moves to the next index after blue. A second data port uses the same sequencer, but it maps the index onto the four overlay entries.

A combinational lookup port serves the display side. It turns an 8-bit pixel value, or an overlay selection, into packed 24-bit RGB. Register reads come back in the same cycle as the access. State changes at the clock edge, so a component written in one cycle appears on the lookup port from the next cycle onward.

Top module: `clut_top`

## Requirements
- R1: After reset every entry is black (all components 0x00), except entries 255, 256 and 258, which are white (all components 0xFF). The index is 0 and the sequencer points at red.
- R2: A write to byte offset 0 loads the index from data bits 31:24 and returns the sequencer to red.
- R3: Writes to byte offset 4 store data bits 31:24 into entry `index`: red first, then green, then blue. Bits 23:0 are ignored.
- R4: The access that handles blue (offset 4 or 12) adds one to the index modulo 256 (255 wraps to 0) and returns the sequencer to red.
- R5: Reads and writes at byte offset 12 act on entry 256 + index[1:0] with the same red, green, blue order. The full 8-bit index still advances after blue.
- R6: A read at offset 4 or 12 returns the current component of the addressed entry in bits 31:24, with bits 23:0 zero. Reads advance the same sequencer that writes use, so reads and writes can be mixed.
- R7: Any access at an offset other than 0, 4 or 12, and any read at offset 0, changes no state and reads as zero.
- R8: `rgbOut` is {red, green, blue} of entry `pixIndex` when `ovlEn` is 0, and of entry 256 + pixIndex[1:0] when `ovlEn` is 1. It is combinational and shows a written component from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access present this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 4 | Byte offset of the access |
| busWdata | input | 32 | Write data; component in bits 31:24 |
| busRdata | output | 32 | Read data, valid in the access cycle |
| pixIndex | input | 8 | Pixel value to look up |
| ovlEn | input | 1 | Select overlay entry 256 + pixIndex[1:0] |
| rgbOut | output | 24 | Looked-up colour {R, G, B} |

## Verification
A register write to an entry and a lookup of that same entry can occur in the same cycle. The bench sets `pixIndex` to the entry being written while red, green and blue are written. The reference model expects the old colour in the write cycle and the updated colour in the following cycle. A read and a write can also share the one sequencer in back-to-back cycles. This is provoked by interleaving reads and writes at offsets 4 and 12. Every cycle is judged against the model's component position and index.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int IDX_W       = 8;
  localparam int OVL_W       = 2;
  localparam int COMP_W      = 8;
  localparam int ENTRY_W     = IDX_W + 1;
  localparam int NUM_NORMAL  = 1 << IDX_W;
  localparam int NUM_OVL     = 1 << OVL_W;
  localparam int NUM_ENTRIES = NUM_NORMAL + NUM_OVL;

  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;

  // Strobes from the sequencer to the table storage
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [ENTRY_W-1:0] entry;
    comp_e             comp;
    logic [COMP_W-1:0] wrVal;
  } lut_strobe_t;
endpackage

// File: rtl/clut_seq_ctrl.sv
module clut_seq_ctrl
  import clut_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int OFF_INDEX   = 0,
  parameter int OFF_COLOR   = 4,
  parameter int OFF_OVERLAY = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output lut_strobe_t       strobe
);
  localparam int TOP = BUS_W - 1;

  logic [IDX_W-1:0]  idxQ;
  comp_e             seqQ;
  comp_e             seqNext;
  logic              hitIndex, hitColor, hitOvl, hitData;
  logic [COMP_W-1:0] compIn;
  logic              unusedWdata;

  assign hitIndex = busValid && busWrite && (busAddr == ADDR_W'(OFF_INDEX));
  assign hitColor = busValid && (busAddr == ADDR_W'(OFF_COLOR));
  assign hitOvl   = busValid && (busAddr == ADDR_W'(OFF_OVERLAY));
  assign hitData  = hitColor || hitOvl;
  assign compIn   = busWdata[TOP -: COMP_W];
  assign unusedWdata = ^busWdata[TOP-COMP_W:0];

  always_comb begin
    case (seqQ)
      COMP_R:  seqNext = COMP_G;
      COMP_G:  seqNext = COMP_B;
      default: seqNext = COMP_R;
    endcase
  end

  always_comb begin
    strobe.wrEn  = hitData && busWrite;
    strobe.rdEn  = hitData && !busWrite;
    strobe.comp  = seqQ;
    strobe.wrVal = compIn;
    if (hitOvl)
      strobe.entry = {1'b1, {(IDX_W-OVL_W){1'b0}}, idxQ[OVL_W-1:0]};
    else
      strobe.entry = {1'b0, idxQ};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      seqQ <= COMP_R;
    end else if (hitIndex) begin
      idxQ <= compIn[IDX_W-1:0];
      seqQ <= COMP_R;
    end else if (hitData) begin
      seqQ <= seqNext;
      if (seqQ == COMP_B) idxQ <= idxQ + 1'b1;
    end
  end

  // R2: index load also rewinds the sequencer
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rstN)
    hitIndex |=> (idxQ == $past(busWdata[TOP -: IDX_W])) && (seqQ == COMP_R));

  // R4: blue access advances the index modulo 256
  a_r4_advance_after_blue: assert property (@(posedge clk) disable iff (!rstN)
    (hitData && seqQ == COMP_B) |=> (idxQ == IDX_W'($past(idxQ) + 1'b1)) && (seqQ == COMP_R));

  // R7: other offsets leave index and sequencer untouched
  a_r7_other_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!hitIndex && !hitData) |=> $stable(idxQ) && $stable(seqQ));

  // R3: sequencer never leaves the three legal states
  a_r3_seq_legal: assert property (@(posedge clk) disable iff (!rstN)
    seqQ != comp_e'(2'd3));
endmodule

// File: rtl/clut_store.sv
module clut_store
  import clut_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int WHITE_A = 255,
  parameter int WHITE_B = 256,
  parameter int WHITE_C = 258
) (
  input  logic              clk,
  input  logic              rstN,
  input  lut_strobe_t       strobe,
  input  logic [IDX_W-1:0]  pixIndex,
  input  logic              ovlEn,
  output logic [BUS_W-1:0]  busRdata,
  output logic [3*COMP_W-1:0] rgbOut
);
  logic [COMP_W-1:0] redQ   [NUM_ENTRIES];
  logic [COMP_W-1:0] greenQ [NUM_ENTRIES];
  logic [COMP_W-1:0] blueQ  [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    localparam logic [COMP_W-1:0] RST_VAL =
      (e == WHITE_A || e == WHITE_B || e == WHITE_C) ? {COMP_W{1'b1}} : '0;
    logic hit;
    assign hit = strobe.wrEn && (strobe.entry == ENTRY_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        redQ[e]   <= RST_VAL;
        greenQ[e] <= RST_VAL;
        blueQ[e]  <= RST_VAL;
      end else if (hit) begin
        case (strobe.comp)
          COMP_R:  redQ[e]   <= strobe.wrVal;
          COMP_G:  greenQ[e] <= strobe.wrVal;
          default: blueQ[e]  <= strobe.wrVal;
        endcase
      end
    end
  end

  logic [COMP_W-1:0]  rdComp;
  logic [ENTRY_W-1:0] lkEntry;

  always_comb begin
    case (strobe.comp)
      COMP_R:  rdComp = redQ[strobe.entry];
      COMP_G:  rdComp = greenQ[strobe.entry];
      default: rdComp = blueQ[strobe.entry];
    endcase
    busRdata = strobe.rdEn ? {rdComp, {(BUS_W-COMP_W){1'b0}}} : '0;
  end

  assign lkEntry = ovlEn ? {1'b1, {(IDX_W-OVL_W){1'b0}}, pixIndex[OVL_W-1:0]}
                         : {1'b0, pixIndex};
  assign rgbOut  = {redQ[lkEntry], greenQ[lkEntry], blueQ[lkEntry]};

  // R5: a write never targets beyond the overlay entries
  a_r5_entry_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (strobe.entry < ENTRY_W'(NUM_ENTRIES)));

  // R3: a red write lands in the selected entry
  a_r3_red_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.comp == COMP_R) |=> redQ[$past(strobe.entry)] == $past(strobe.wrVal));

  // R3: a blue write lands in the selected entry
  a_r3_blue_lands: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.comp == COMP_B) |=> blueQ[$past(strobe.entry)] == $past(strobe.wrVal));
endmodule

// File: rtl/clut_top.sv
module clut_top
  import clut_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [7:0]        pixIndex,
  input  logic              ovlEn,
  output logic [23:0]       rgbOut
);
  lut_strobe_t strobe;

  clut_seq_ctrl #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  clut_store #(.BUS_W(BUS_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pixIndex (pixIndex),
    .ovlEn    (ovlEn),
    .busRdata (busRdata),
    .rgbOut   (rgbOut)
  );
endmodule

// File: tb/clut_top_bench.sv
module clut_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pixIndex = '0;
  logic        ovlEn = 1'b0;
  logic [23:0] rgbOut;

  int total = 0;
  int fails = 0;

  // behavioural reference
  logic [23:0] refRgb [260];
  int refIdx = 0;
  int refSeq = 0;

  always #10 clk = ~clk;

  clut_top u_clut_top (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pixIndex(pixIndex), .ovlEn(ovlEn), .rgbOut(rgbOut)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int tgtEntry(logic [3:0] a);
    return (a == 4'd12) ? 256 + (refIdx % 4) : refIdx;
  endfunction

  task automatic acc(bit v, bit w, logic [3:0] a, logic [31:0] d,
                     logic [7:0] pix, bit ovl, string tag);
    logic [31:0] expRd;
    int e, lk;
    @(negedge clk);
    busValid = v; busWrite = w; busAddr = a; busWdata = d;
    pixIndex = pix; ovlEn = ovl;
    #1;
    expRd = '0;
    if (v && !w && (a == 4'd4 || a == 4'd12)) begin
      e = tgtEntry(a);
      expRd = {refRgb[e][23 - 8*refSeq -: 8], 24'h0};
    end
    chk(tag, "busRdata", busRdata, expRd);
    lk = ovl ? 256 + int'(pix[1:0]) : int'(pix);
    chk(tag, "rgbOut", {8'h0, rgbOut}, {8'h0, refRgb[lk]});
    @(posedge clk);
    if (v && w && a == 4'd0) begin
      refIdx = int'(d[31:24]);
      refSeq = 0;
    end else if (v && (a == 4'd4 || a == 4'd12)) begin
      e = tgtEntry(a);
      if (w) refRgb[e][23 - 8*refSeq -: 8] = d[31:24];
      if (refSeq == 2) begin
        refSeq = 0;
        refIdx = (refIdx + 1) % 256;
      end else refSeq++;
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] val, logic [7:0] pix, bit ovl, string tag);
    acc(1'b1, 1'b1, a, {val, 24'hA5C3E1}, pix, ovl, tag);
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] pix, bit ovl, string tag);
    acc(1'b1, 1'b0, a, 32'hFFFF_FFFF, pix, ovl, tag);
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 260; i++)
      refRgb[i] = (i == 255 || i == 256 || i == 258) ? 24'hFFFFFF : 24'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset contents through the lookup port
    for (int p = 0; p < 256; p++) acc(1'b0, 1'b0, 4'd0, '0, 8'(p), 1'b0, "R1");
    for (int p = 0; p < 4; p++)   acc(1'b0, 1'b0, 4'd0, '0, 8'(p), 1'b1, "R1");

    // R2/R3: load index, then red/green/blue; R8 same-cycle lookup of the entry
    wr(4'd0, 8'd10, 8'd10, 1'b0, "R2");
    wr(4'd4, 8'h12, 8'd10, 1'b0, "R3");
    wr(4'd4, 8'h34, 8'd10, 1'b0, "R8");
    wr(4'd4, 8'h56, 8'd10, 1'b0, "R8");
    acc(1'b0, 1'b0, 4'd0, '0, 8'd10, 1'b0, "R8");
    // R4: index advanced to 11
    wr(4'd4, 8'h9A, 8'd11, 1'b0, "R4");
    // R2: address write rewinds sequencer to red
    wr(4'd0, 8'd20, 8'd20, 1'b0, "R2");
    wr(4'd4, 8'h77, 8'd20, 1'b0, "R2");
    wr(4'd0, 8'd20, 8'd20, 1'b0, "R2");
    wr(4'd4, 8'h01, 8'd20, 1'b0, "R2");
    wr(4'd4, 8'h02, 8'd20, 1'b0, "R2");
    wr(4'd4, 8'h03, 8'd20, 1'b0, "R2");
    acc(1'b0, 1'b0, 4'd0, '0, 8'd20, 1'b0, "R2");

    // R4: wrap 255 -> 0
    wr(4'd0, 8'd255, 8'd255, 1'b0, "R4");
    wr(4'd4, 8'h11, 8'd255, 1'b0, "R4");
    wr(4'd4, 8'h22, 8'd255, 1'b0, "R4");
    wr(4'd4, 8'h33, 8'd255, 1'b0, "R4");
    wr(4'd4, 8'h44, 8'd0, 1'b0, "R4");
    wr(4'd4, 8'h55, 8'd0, 1'b0, "R4");
    wr(4'd4, 8'h66, 8'd0, 1'b0, "R4");
    acc(1'b0, 1'b0, 4'd0, '0, 8'd0, 1'b0, "R4");
    acc(1'b0, 1'b0, 4'd0, '0, 8'd1, 1'b0, "R4");

    // R5: overlay port, index 6 -> entry 258, then index 7 -> entry 259
    wr(4'd0, 8'd6, 8'd2, 1'b1, "R5");
    wr(4'd12, 8'h81, 8'd2, 1'b1, "R5");
    wr(4'd12, 8'h82, 8'd2, 1'b1, "R5");
    wr(4'd12, 8'h83, 8'd2, 1'b1, "R5");
    wr(4'd12, 8'hC1, 8'd3, 1'b1, "R5");
    wr(4'd12, 8'hC2, 8'd3, 1'b1, "R5");
    wr(4'd12, 8'hC3, 8'd3, 1'b1, "R5");
    acc(1'b0, 1'b0, 4'd0, '0, 8'd8, 1'b0, "R5");
    // R5: overlay at index 255 -> entry 259, index wraps to 0
    wr(4'd0, 8'd255, 8'd3, 1'b1, "R5");
    wr(4'd12, 8'hE1, 8'd3, 1'b1, "R5");
    wr(4'd12, 8'hE2, 8'd3, 1'b1, "R5");
    wr(4'd12, 8'hE3, 8'd3, 1'b1, "R5");
    rd(4'd4, 8'd3, 1'b1, "R5");

    // R6: read back entry 10, mixed read/write sharing the sequencer
    wr(4'd0, 8'd10, 8'd10, 1'b0, "R6");
    rd(4'd4, 8'd10, 1'b0, "R6");
    rd(4'd4, 8'd10, 1'b0, "R6");
    rd(4'd4, 8'd10, 1'b0, "R6");
    rd(4'd4, 8'd11, 1'b0, "R6");
    wr(4'd4, 8'hBB, 8'd11, 1'b0, "R6");
    rd(4'd4, 8'd11, 1'b0, "R6");
    rd(4'd12, 8'd0, 1'b1, "R6");
    wr(4'd0, 8'd6, 8'd2, 1'b1, "R6");
    rd(4'd12, 8'd2, 1'b1, "R6");
    wr(4'd12, 8'h99, 8'd2, 1'b1, "R6");
    rd(4'd12, 8'd2, 1'b1, "R6");

    // R7: other offsets ignored, read zero, state unchanged
    wr(4'd0, 8'd30, 8'd30, 1'b0, "R7");
    wr(4'd4, 8'h5E, 8'd30, 1'b0, "R7");
    wr(4'd8, 8'hFF, 8'd30, 1'b0, "R7");
    wr(4'd1, 8'hFF, 8'd30, 1'b0, "R7");
    wr(4'd5, 8'hFF, 8'd30, 1'b0, "R7");
    rd(4'd8, 8'd30, 1'b0, "R7");
    rd(4'd0, 8'd30, 1'b0, "R7");
    wr(4'd4, 8'h6E, 8'd30, 1'b0, "R7");
    wr(4'd4, 8'h7E, 8'd30, 1'b0, "R7");
    acc(1'b0, 1'b0, 4'd0, '0, 8'd30, 1'b0, "R7");
    rd(4'd4, 8'd31, 1'b0, "R7");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule